// File: doc/BRIEF.md
# SDRAM Refresh Request Arbiter

This block decides when an auto-refresh may be launched on a shared SDRAM bus. A periodic timer outside the block supplies a one-cycle interval tick. The block holds that request in a single pending slot until the bus is free. The bus is free when no bus cycle is running, ownership has not been handed to another master, and self-refresh is not active. It then emits a one-clock refresh-start strobe.

While a refresh is held because another master owns the bus, the block drives an active-low bus-request output to win ownership back. A new tick that lands on an already pending request replaces it, and a one-cycle dropped pulse marks the lost refresh. The block also grants the bus to an external requester. That grant is refused while self-refresh is active, and a pending refresh takes precedence over it.

All outputs are registered. Each output reflects the inputs sampled at the previous clock edge.

Top module: `rfsh_arb`

## Requirements
- R1: After reset, rfsh_start_o is 0, bus_req_n_o is 1, rel_grant_o is 0 and lost_o is 0.
- R2: A tick sampled at edge N on an idle bus makes pending set at edge N; rfsh_start_o is 1 after edge N+1 for exactly one cycle, and pending clears at that same edge.
- R3: While cyc_busy_i is 1 a pending refresh does not start; it starts at the first edge at which cyc_busy_i is sampled 0.
- R4: While bus_away_i is 1 a pending refresh does not start; it starts at the first edge at which bus_away_i is sampled 0.
- R5: bus_req_n_o is 0 after every edge that samples a pending refresh together with bus_away_i = 1, and returns to 1 after the first edge that samples bus_away_i = 0.
- R6: A tick sampled while a refresh is pending and not being launched at that edge replaces it: lost_o is 1 for that one cycle, and only one refresh start follows.
- R7: A tick sampled at the same edge that launches a refresh becomes the new pending request: lost_o stays 0 and a second refresh start follows.
- R8: While self_ref_i is 1, rel_grant_o is 0 whatever ext_req_i is; the grant is given after the first edge that samples self_ref_i = 0 with the request still present.
- R9: When a refresh is pending and ext_req_i is 1 on an idle bus, the refresh starts first and rel_grant_o stays 0 until the edge after pending has cleared.
- R10: rel_grant_o rises after an edge that samples ext_req_i = 1, idle bus, no pending refresh and no self-refresh; it stays 1 while ext_req_i stays 1, and falls after the edge that samples ext_req_i = 0.
- R11: No refresh start is launched while self_ref_i is sampled 1; a held refresh starts at the first edge that samples self_ref_i = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Refresh-interval tick from the timer |
| cyc_busy_i | input | 1 | A bus cycle is in progress |
| bus_away_i | input | 1 | Bus ownership has been handed to another master |
| ext_req_i | input | 1 | External master requests the bus |
| self_ref_i | input | 1 | Self-refresh is active |
| rfsh_start_o | output | 1 | One-clock strobe that launches an auto-refresh |
| bus_req_n_o | output | 1 | Active-low request to regain the bus for a refresh |
| rel_grant_o | output | 1 | Bus released to the external master |
| lost_o | output | 1 | One-cycle pulse when a pending refresh is overwritten |

## Verification
The assertions assume that the inputs only change between clock edges. They also assume that bus_away_i is 1 only while rel_grant_o is 1 or shortly after it falls, as a real bus arbiter would behave. Beyond that they treat cyc_busy_i, tick_i and self_ref_i as unconstrained. The bench drives every input a short delay after the rising edge and holds it there. It raises bus_away_i only in its ownership scenario and lowers it again before the next scenario, so no case depends on an arbiter model.

// File: rtl/rfsh_arb_pkg.sv
package rfsh_arb_pkg;

  // A refresh may be launched when one is pending and the bus is free.
  function automatic logic f_launch(input logic pend, input logic busy,
                                    input logic away, input logic sref);
    return pend & ~busy & ~away & ~sref;
  endfunction

  // Next state of the single pending slot.
  function automatic logic f_pend_next(input logic tick, input logic pend,
                                       input logic launch);
    return tick | (pend & ~launch);
  endfunction

  // A request is lost when a tick overwrites one that is not leaving.
  function automatic logic f_lost(input logic tick, input logic pend,
                                  input logic launch);
    return tick & pend & ~launch;
  endfunction

  // Release grant: new grant only on an idle bus with nothing pending,
  // kept while the request stays, always refused in self-refresh.
  function automatic logic f_grant_next(input logic req, input logic sref,
                                        input logic held, input logic busy,
                                        input logic pend);
    return req & ~sref & (held | (~busy & ~pend));
  endfunction

endpackage

// File: rtl/rfsh_arb_slot.sv
module rfsh_arb_slot
  import rfsh_arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic cyc_busy_i,
  input  logic bus_away_i,
  input  logic self_ref_i,
  output logic pend_o,
  output logic start_o,
  output logic lost_o
);

  logic pend_q;
  logic launch_w;

  assign launch_w = f_launch(pend_q, cyc_busy_i, bus_away_i, self_ref_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      start_o <= 1'b0;
      lost_o  <= 1'b0;
    end else begin
      pend_q  <= f_pend_next(tick_i, pend_q, launch_w);
      start_o <= launch_w;
      lost_o  <= f_lost(tick_i, pend_q, launch_w);
    end
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/rfsh_arb_breq.sv
module rfsh_arb_breq (
  input  logic clk,
  input  logic rst_n,
  input  logic pend_i,
  input  logic bus_away_i,
  output logic bus_req_n_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) bus_req_n_o <= 1'b1;
    else        bus_req_n_o <= ~(pend_i & bus_away_i);
  end

endmodule

// File: rtl/rfsh_arb_grant.sv
module rfsh_arb_grant
  import rfsh_arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ext_req_i,
  input  logic self_ref_i,
  input  logic cyc_busy_i,
  input  logic pend_i,
  output logic grant_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) grant_o <= 1'b0;
    else        grant_o <= f_grant_next(ext_req_i, self_ref_i, grant_o,
                                        cyc_busy_i, pend_i);
  end

endmodule

// File: rtl/rfsh_arb.sv
module rfsh_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic cyc_busy_i,
  input  logic bus_away_i,
  input  logic ext_req_i,
  input  logic self_ref_i,
  output logic rfsh_start_o,
  output logic bus_req_n_o,
  output logic rel_grant_o,
  output logic lost_o
);

  // Named internal event, brought out for the checker.
  logic rfa_pend;

  rfsh_arb_slot u_slot (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .cyc_busy_i (cyc_busy_i),
    .bus_away_i (bus_away_i),
    .self_ref_i (self_ref_i),
    .pend_o     (rfa_pend),
    .start_o    (rfsh_start_o),
    .lost_o     (lost_o)
  );

  rfsh_arb_breq u_breq (
    .clk         (clk),
    .rst_n       (rst_n),
    .pend_i      (rfa_pend),
    .bus_away_i  (bus_away_i),
    .bus_req_n_o (bus_req_n_o)
  );

  rfsh_arb_grant u_grant (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_req_i  (ext_req_i),
    .self_ref_i (self_ref_i),
    .cyc_busy_i (cyc_busy_i),
    .pend_i     (rfa_pend),
    .grant_o    (rel_grant_o)
  );

endmodule

// File: rtl/rfsh_arb_chk.sv
module rfsh_arb_chk (
  input logic clk,
  input logic rst_n,
  input logic tick_i,
  input logic cyc_busy_i,
  input logic bus_away_i,
  input logic ext_req_i,
  input logic self_ref_i,
  input logic rfsh_start_o,
  input logic bus_req_n_o,
  input logic rel_grant_o,
  input logic lost_o,
  input logic rfa_pend
);

  // R3: a start is never launched from a busy cycle
  a_r3_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_start_o |-> $past(!cyc_busy_i));

  // R4: a start is never launched while the bus is away
  a_r4_no_start_away: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_start_o |-> $past(!bus_away_i));

  // R11: a start is never launched during self-refresh
  a_r11_no_start_sref: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_start_o |-> $past(!self_ref_i));

  // R5: request pin releases the cycle after ownership returns
  a_r5_breq_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_away_i) |=> bus_req_n_o);

  // R2: a launched refresh leaves the slot empty unless a tick refilled it
  a_r2_slot_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rfsh_start_o && !$past(tick_i)) |-> !rfa_pend);

  // R6: a lost request never coincides with a launch
  a_r6_lost_excl: assert property (@(posedge clk) disable iff (!rst_n)
    lost_o |-> (!rfsh_start_o && rfa_pend));

  // R8: no grant is driven from a self-refresh cycle
  a_r8_no_grant_sref: assert property (@(posedge clk) disable iff (!rst_n)
    rel_grant_o |-> $past(!self_ref_i));

  // R9: a fresh grant never rises over a pending refresh
  a_r9_refresh_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rel_grant_o) |-> $past(!rfa_pend));

  // R10: grant needs a live request
  a_r10_grant_req: assert property (@(posedge clk) disable iff (!rst_n)
    rel_grant_o |-> $past(ext_req_i));

endmodule

bind rfsh_arb rfsh_arb_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick_i       (tick_i),
  .cyc_busy_i   (cyc_busy_i),
  .bus_away_i   (bus_away_i),
  .ext_req_i    (ext_req_i),
  .self_ref_i   (self_ref_i),
  .rfsh_start_o (rfsh_start_o),
  .bus_req_n_o  (bus_req_n_o),
  .rel_grant_o  (rel_grant_o),
  .lost_o       (lost_o),
  .rfa_pend     (rfa_pend)
);

// File: tb/rfsh_arb_bench.sv
module rfsh_arb_bench;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b0, cyc_busy_i = 1'b0, bus_away_i = 1'b0;
  logic ext_req_i = 1'b0, self_ref_i = 1'b0;
  logic rfsh_start_o, bus_req_n_o, rel_grant_o, lost_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rfsh_arb u_rfsh_arb (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cyc_busy_i(cyc_busy_i),
    .bus_away_i(bus_away_i), .ext_req_i(ext_req_i), .self_ref_i(self_ref_i),
    .rfsh_start_o(rfsh_start_o), .bus_req_n_o(bus_req_n_o),
    .rel_grant_o(rel_grant_o), .lost_o(lost_o)
  );

  // Advance past one rising edge; drive and sample away from the edge.
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", what, act, exp);
    end
  endtask

  task automatic t_reset();
    check(rfsh_start_o, 1'b0, "R1 start after reset");
    check(bus_req_n_o,  1'b1, "R1 bus request after reset");
    check(rel_grant_o,  1'b0, "R1 grant after reset");
    check(lost_o,       1'b0, "R1 lost after reset");
  endtask

  task automatic t_idle();
    tick_i = 1'b1; step(); tick_i = 1'b0;
    check(rfsh_start_o, 1'b0, "R2 no start at tick edge");
    step();
    check(rfsh_start_o, 1'b1, "R2 start one edge after pending");
    step();
    check(rfsh_start_o, 1'b0, "R2 strobe one clock wide");
  endtask

  task automatic t_busy();
    cyc_busy_i = 1'b1;
    tick_i = 1'b1; step(); tick_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      step();
      check(rfsh_start_o, 1'b0, "R3 held during busy cycle");
    end
    cyc_busy_i = 1'b0; step();
    check(rfsh_start_o, 1'b1, "R3 start after busy ends");
    step();
    check(rfsh_start_o, 1'b0, "R3 single start");
  endtask

  task automatic t_away();
    bus_away_i = 1'b1;
    tick_i = 1'b1; step(); tick_i = 1'b0;
    step();
    check(bus_req_n_o, 1'b0, "R5 request low while away");
    step();
    check(rfsh_start_o, 1'b0, "R4 held while away");
    check(bus_req_n_o, 1'b0, "R5 request stays low");
    bus_away_i = 1'b0; step();
    check(bus_req_n_o, 1'b1, "R5 request high after return");
    check(rfsh_start_o, 1'b1, "R4 start after return");
    step();
    check(rfsh_start_o, 1'b0, "R4 single start");
  endtask

  task automatic t_double();
    int starts;
    starts = 0;
    cyc_busy_i = 1'b1;
    tick_i = 1'b1; step(); tick_i = 1'b0;
    check(lost_o, 1'b0, "R6 first tick not lost");
    step();
    tick_i = 1'b1; step(); tick_i = 1'b0;
    check(lost_o, 1'b1, "R6 overwrite flagged");
    step();
    check(lost_o, 1'b0, "R6 lost pulse one cycle");
    cyc_busy_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      step();
      if (rfsh_start_o) starts++;
    end
    check(starts == 1, 1'b1, "R6 only one start after overwrite");
  endtask

  task automatic t_coincide();
    int starts;
    starts = 0;
    tick_i = 1'b1; step();
    step(); tick_i = 1'b0;
    check(rfsh_start_o, 1'b1, "R7 first start");
    check(lost_o, 1'b0, "R7 coinciding tick not lost");
    starts++;
    for (int i = 0; i < 3; i++) begin
      step();
      if (rfsh_start_o) starts++;
      check(lost_o, 1'b0, "R7 no loss afterwards");
    end
    check(starts == 2, 1'b1, "R7 second start follows");
  endtask

  task automatic t_sref_grant();
    self_ref_i = 1'b1; ext_req_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step();
      check(rel_grant_o, 1'b0, "R8 grant refused in self-refresh");
    end
    self_ref_i = 1'b0; step();
    check(rel_grant_o, 1'b1, "R8 grant after self-refresh exit");
    step();
    check(rel_grant_o, 1'b1, "R10 grant held with request");
    ext_req_i = 1'b0; step();
    check(rel_grant_o, 1'b0, "R10 grant drops with request");
  endtask

  task automatic t_sref_refresh();
    self_ref_i = 1'b1;
    tick_i = 1'b1; step(); tick_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      step();
      check(rfsh_start_o, 1'b0, "R11 no start in self-refresh");
    end
    self_ref_i = 1'b0; step();
    check(rfsh_start_o, 1'b1, "R11 start after self-refresh exit");
    step();
  endtask

  task automatic t_priority();
    cyc_busy_i = 1'b1;
    tick_i = 1'b1; step(); tick_i = 1'b0;
    ext_req_i = 1'b1; step();
    check(rel_grant_o, 1'b0, "R9 no grant while busy and pending");
    cyc_busy_i = 1'b0; step();
    check(rfsh_start_o, 1'b1, "R9 refresh starts first");
    check(rel_grant_o, 1'b0, "R9 grant withheld at refresh launch");
    step();
    check(rel_grant_o, 1'b1, "R9 grant after pending cleared");
    ext_req_i = 1'b0; step();
    check(rel_grant_o, 1'b0, "R10 grant released");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(); step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_idle();          step();
    t_busy();          step();
    t_away();          step();
    t_double();        step();
    t_coincide();      step();
    t_sref_grant();    step();
    t_sref_refresh();  step();
    t_priority();      step();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule